// File: doc/BRIEF.md
# Conflict-Fill Two-Way Instruction Cache

This block sits next to a program sequencer whose one program-memory bus carries both instruction fetches and data reads or writes. When a fetch and a data access want the bus in the same cycle, the data access keeps the bus. The cache is searched for the instruction. A hit supplies the instruction at once, so the conflict costs no cycle. A miss stalls the sequencer for one cycle. In the next cycle the block fetches the instruction over the bus and keeps a copy. A later conflict on the same address then hits.

A fetch with no data access on the bus goes straight to memory. It never looks at the cache, never stores into it and never changes its replacement state. The storage is 16 sets of two 48-bit entries each, held in registers. Each set has one replacement bit. An enable input, a freeze input and a flush input let the sequencer bypass, lock or empty the cache.

Top module: `conflict_icache`

## Requirements
- R1: After synchronous reset every entry is invalid, so the first conflicting fetch to any address misses. With no fetch requested, the outputs `instr_valid`, `mem_fetch`, `stall` and `hit` are all 0.
- R2: A fetch with `data_req` low and no fill pending is served by memory in the same cycle. The outputs are `mem_fetch`=1, `mem_addr`=`fetch_addr`, `instr_valid`=1 and `instr_word`=`mem_rdata`. It never allocates an entry and never changes a replacement bit.
- R3: A conflicting fetch (`fetch_req` and `data_req` both high, `cache_en` high) that hits returns the stored word in the same cycle. The outputs are `hit`=1, `instr_valid`=1, `stall`=0 and `mem_fetch`=0.
- R4: A conflicting fetch that misses raises `stall` for that cycle, with `mem_fetch`=0 and `instr_valid`=0. In the next cycle the block drives the stalled address on `mem_addr` with `mem_fetch`=1 and returns `mem_rdata` with `instr_valid`=1. All fetch and data inputs in that fill cycle are ignored.
- R5: The fill cycle writes the instruction into the set chosen by address bits 3..0 and tags it with bits 23..4. A later conflicting fetch to the same address hits and returns that word. An address with the same set bits but a different tag misses.
- R6: A fill goes to way 0 if way 0 is invalid, otherwise to way 1 if way 1 is invalid, otherwise to the way named by the set's replacement bit. After a hit or a fill, that bit names the other way.
- R7: While `freeze` is high in the fill cycle, nothing is written. Hits are still served and still update the replacement bit.
- R8: `flush` clears every valid bit at the end of its cycle. A fill in the same cycle is discarded. The cycle after a flush cannot hit.
- R9: While `cache_en` is low, every conflicting fetch stalls and fills nothing, and no replacement bit changes. The stored contents survive, and hits return once `cache_en` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Enables lookup and allocation on conflicts |
| freeze | input | 1 | Blocks fills; hits still served |
| flush | input | 1 | Invalidates all entries at the end of the cycle |
| fetch_req | input | 1 | Sequencer requests an instruction this cycle |
| fetch_addr | input | 24 | Instruction fetch address |
| data_req | input | 1 | A data access occupies the program-memory bus this cycle |
| mem_rdata | input | 48 | Instruction word read from program memory at `mem_addr` |
| mem_addr | output | 24 | Fetch address presented to program memory |
| mem_fetch | output | 1 | The bus performs an instruction fetch this cycle |
| instr_valid | output | 1 | `instr_word` holds the requested instruction |
| instr_word | output | 48 | Delivered instruction |
| stall | output | 1 | Sequencer must hold; fetch completes next cycle |
| hit | output | 1 | Instruction came from the cache |

## Verification
Some properties are checked on every cycle. A hit never uses the bus or stalls, and a stall is always followed by a bus fetch in the next cycle. A conflict outside a fill cycle never puts a fetch on the bus. No hit happens while the cache is disabled or just after a flush, and an idle cycle produces no output. Which way a fill replaces, whether allocation happened and what freeze does depend on the history of the cache contents. Only the bench's behavioural model of the sets, tags and replacement bits can show these, by following the scripted conflict sequences and a long random mix.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int ADDR_W  = 24;
    localparam int INSTR_W = 48;
    localparam int SETS    = 16;
    localparam int WAYS    = 2;
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [TAG_W-1:0]   tag_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } tag_ent_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_BYPASS,
        ACT_HIT,
        ACT_MISS,
        ACT_FILL
    } act_e;

    function automatic idx_t addr_idx(input addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t addr_tag(input addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    // Lowest invalid way first, otherwise the way the replacement bit names.
    function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
        if (!v0) return 1'b0;
        if (!v1) return 1'b1;
        return lru;
    endfunction
endpackage

// File: rtl/icache_tags.sv
module icache_tags
    import icache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  addr_t lk_addr,
    input  addr_t fl_addr,
    input  logic  wr_en,
    input  logic  touch_en,
    input  idx_t  touch_idx,
    input  logic  touch_way,
    output logic  lk_hit,
    output logic  lk_way,
    output logic  fl_way
);
    tag_ent_t         ent [SETS][WAYS];
    logic [SETS-1:0]  lru;
    logic [WAYS-1:0]  match;
    idx_t             li;
    idx_t             fi;

    assign li = addr_idx(lk_addr);
    assign fi = addr_idx(fl_addr);

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = ent[li][w].valid && (ent[li][w].tag == addr_tag(lk_addr));
        end
    endgenerate

    assign lk_hit = |match;
    assign lk_way = match[1];
    assign fl_way = pick_victim(ent[fi][0].valid, ent[fi][1].valid, lru[fi]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent[s][w].valid <= 1'b0;
            lru <= '0;
        end else begin
            if (wr_en)
                ent[fi][fl_way] <= '{valid: 1'b1, tag: addr_tag(fl_addr)};
            if (touch_en)
                lru[touch_idx] <= ~touch_way;
            if (flush)
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        ent[s][w].valid <= 1'b0;
        end
    end
endmodule

// File: rtl/icache_data.sv
module icache_data
    import icache_pkg::*;
(
    input  logic   clk,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  logic   wr_way,
    input  instr_t wr_word,
    input  idx_t   rd_idx,
    input  logic   rd_way,
    output instr_t rd_word
);
    instr_t mem [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx][wr_way] <= wr_word;
    end

    assign rd_word = mem[rd_idx][rd_way];
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cache_en,
    input  logic   freeze,
    input  logic   flush,
    input  logic   fetch_req,
    input  addr_t  fetch_addr,
    input  logic   data_req,
    input  instr_t mem_rdata,
    input  logic   lk_hit,
    input  logic   lk_way,
    input  logic   fl_way,
    input  instr_t cache_word,
    output addr_t  mem_addr,
    output logic   mem_fetch,
    output logic   instr_valid,
    output instr_t instr_word,
    output logic   stall,
    output logic   hit,
    output addr_t  fl_addr,
    output logic   fill_en,
    output logic   touch_en,
    output idx_t   touch_idx,
    output logic   touch_way
);
    logic  pend;
    logic  palloc;
    addr_t paddr;
    act_e  act;

    always_comb begin
        act = ACT_IDLE;
        if (pend)
            act = ACT_FILL;
        else if (fetch_req && data_req)
            act = (cache_en && lk_hit) ? ACT_HIT : ACT_MISS;
        else if (fetch_req)
            act = ACT_BYPASS;
    end

    assign stall       = (act == ACT_MISS);
    assign hit         = (act == ACT_HIT);
    assign mem_fetch   = (act == ACT_FILL) || (act == ACT_BYPASS);
    assign instr_valid = mem_fetch || hit;
    assign instr_word  = hit ? cache_word : mem_rdata;
    assign mem_addr    = pend ? paddr : fetch_addr;
    assign fl_addr     = paddr;

    assign fill_en   = (act == ACT_FILL) && palloc && !freeze && !flush;
    assign touch_en  = hit || fill_en;
    assign touch_idx = hit ? addr_idx(fetch_addr) : addr_idx(paddr);
    assign touch_way = hit ? lk_way : fl_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            palloc <= 1'b0;
            paddr  <= '0;
        end else begin
            pend <= (act == ACT_MISS);
            if (act == ACT_MISS) begin
                paddr  <= fetch_addr;
                palloc <= cache_en;
            end
        end
    end
endmodule

// File: rtl/conflict_icache.sv
module conflict_icache
    import icache_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cache_en,
    input  logic                freeze,
    input  logic                flush,
    input  logic                fetch_req,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                data_req,
    input  logic [INSTR_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_fetch,
    output logic                instr_valid,
    output logic [INSTR_W-1:0]  instr_word,
    output logic                stall,
    output logic                hit
);
    logic   lk_hit, lk_way, fl_way;
    logic   fill_en, touch_en, touch_way;
    idx_t   touch_idx;
    addr_t  fl_addr;
    instr_t cache_word;

    icache_tags u_tags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_addr   (fetch_addr),
        .fl_addr   (fl_addr),
        .wr_en     (fill_en),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .fl_way    (fl_way)
    );

    icache_data u_data (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_idx  (addr_idx(fl_addr)),
        .wr_way  (fl_way),
        .wr_word (mem_rdata),
        .rd_idx  (addr_idx(fetch_addr)),
        .rd_way  (lk_way),
        .rd_word (cache_word)
    );

    icache_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cache_en    (cache_en),
        .freeze      (freeze),
        .flush       (flush),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .data_req    (data_req),
        .mem_rdata   (mem_rdata),
        .lk_hit      (lk_hit),
        .lk_way      (lk_way),
        .fl_way      (fl_way),
        .cache_word  (cache_word),
        .mem_addr    (mem_addr),
        .mem_fetch   (mem_fetch),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .stall       (stall),
        .hit         (hit),
        .fl_addr     (fl_addr),
        .fill_en     (fill_en),
        .touch_en    (touch_en),
        .touch_idx   (touch_idx),
        .touch_way   (touch_way)
    );
endmodule

// File: rtl/icache_checker.sv
module icache_checker (
    input logic clk,
    input logic rst,
    input logic cache_en,
    input logic flush,
    input logic fetch_req,
    input logic data_req,
    input logic mem_fetch,
    input logic instr_valid,
    input logic stall,
    input logic hit
);
    a_r3_hit_keeps_bus: assert property (@(posedge clk) disable iff (rst)
        hit |-> (!mem_fetch && !stall && instr_valid));

    a_r4_stall_then_fill: assert property (@(posedge clk) disable iff (rst)
        (!rst && stall) |=> (mem_fetch && instr_valid && !stall));

    a_r4_conflict_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && data_req && !$past(stall)) |-> !mem_fetch);

    a_r8_flush_no_hit: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> !hit);

    a_r9_disabled_no_hit: assert property (@(posedge clk) disable iff (rst)
        !cache_en |-> !hit);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req && !$past(stall)) |-> (!instr_valid && !mem_fetch && !stall));
endmodule

bind conflict_icache icache_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cache_en    (cache_en),
    .flush       (flush),
    .fetch_req   (fetch_req),
    .data_req    (data_req),
    .mem_fetch   (mem_fetch),
    .instr_valid (instr_valid),
    .stall       (stall),
    .hit         (hit)
);

// File: tb/conflict_icache_test.sv
`timescale 1ns/1ps
module conflict_icache_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b0, freeze = 1'b0, flush = 1'b0;
    logic        fetch_req = 1'b0, data_req = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic [47:0] mem_rdata;
    logic [23:0] mem_addr;
    logic        mem_fetch, instr_valid, stall, hit;
    logic [47:0] instr_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [47:0] memf(input logic [23:0] a);
        return {a ^ 24'hA5C3F0, a + 24'h013579};
    endfunction

    assign mem_rdata = memf(mem_addr);

    conflict_icache uut (
        .clk(clk), .rst(rst), .cache_en(cache_en), .freeze(freeze), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .data_req(data_req),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_fetch(mem_fetch),
        .instr_valid(instr_valid), .instr_word(instr_word), .stall(stall), .hit(hit)
    );

    // Behavioural reference state
    bit          m_valid [16][2];
    logic [19:0] m_tag   [16][2];
    logic [47:0] m_data  [16][2];
    bit          m_lru   [16];
    bit          m_pend, m_palloc;
    logic [23:0] m_paddr;

    // Last sampled outputs
    logic s_hit, s_stall, s_fetch, s_valid;
    logic [47:0] s_word;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 16; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) m_valid[s][w] = 0;
        end
        m_pend = 0;
    endtask

    task automatic cyc(input bit en, input bit frz, input bit fl,
                       input bit freq, input logic [23:0] fa, input bit dreq);
        bit e_stall, e_fetch, e_valid, e_hit;
        logic [47:0] e_word;
        logic [23:0] e_addr;
        string req;
        int idx, way;
        bit lhit;
        @(negedge clk);
        cache_en = en; freeze = frz; flush = fl;
        fetch_req = freq; fetch_addr = fa; data_req = dreq;
        #2;
        e_stall = 0; e_fetch = 0; e_valid = 0; e_hit = 0; e_word = '0; e_addr = '0;
        if (m_pend) begin
            req = "R4"; e_fetch = 1; e_valid = 1; e_addr = m_paddr; e_word = memf(m_paddr);
        end else if (freq && dreq) begin
            idx = fa[3:0]; lhit = 0; way = 0;
            for (int w = 0; w < 2; w++)
                if (m_valid[idx][w] && m_tag[idx][w] == fa[23:4]) begin lhit = 1; way = w; end
            if (en && lhit) begin
                req = "R3"; e_hit = 1; e_valid = 1; e_word = m_data[idx][way];
            end else begin
                req = "R4"; e_stall = 1;
            end
        end else if (freq) begin
            req = "R2"; e_fetch = 1; e_valid = 1; e_addr = fa; e_word = memf(fa);
        end else begin
            req = "R1";
        end
        s_hit = hit; s_stall = stall; s_fetch = mem_fetch; s_valid = instr_valid; s_word = instr_word;
        chk(stall === e_stall, req, "stall", 64'(stall), 64'(e_stall));
        chk(hit === e_hit, req, "hit", 64'(hit), 64'(e_hit));
        chk(mem_fetch === e_fetch, req, "mem_fetch", 64'(mem_fetch), 64'(e_fetch));
        chk(instr_valid === e_valid, req, "instr_valid", 64'(instr_valid), 64'(e_valid));
        if (e_valid) chk(instr_word === e_word, req, "instr_word", 64'(instr_word), 64'(e_word));
        if (e_fetch) chk(mem_addr === e_addr, req, "mem_addr", 64'(mem_addr), 64'(e_addr));
        // advance the model
        if (m_pend) begin
            m_pend = 0;
            if (m_palloc && !frz && !fl) begin
                idx = m_paddr[3:0];
                way = !m_valid[idx][0] ? 0 : (!m_valid[idx][1] ? 1 : int'(m_lru[idx]));
                m_valid[idx][way] = 1; m_tag[idx][way] = m_paddr[23:4];
                m_data[idx][way] = memf(m_paddr); m_lru[idx] = (way == 0);
            end
        end else if (freq && dreq) begin
            if (e_hit) m_lru[fa[3:0]] = (way == 0);
            else begin m_pend = 1; m_paddr = fa; m_palloc = en; end
        end
        if (fl)
            for (int s = 0; s < 16; s++)
                for (int w = 0; w < 2; w++) m_valid[s][w] = 0;
    endtask

    // conflict fetch on enabled cache; if it misses, run the fill cycle
    task automatic conflict(input logic [23:0] a, input bit frz);
        cyc(1, frz, 0, 1, a, 1);
        if (s_stall) cyc(1, frz, 0, 0, 24'h0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: idle after reset, first conflict misses
        cyc(1, 0, 0, 0, 24'h0, 0);
        chk(!s_valid && !s_stall, "R1", "idle after reset", 64'({s_valid, s_stall}), 64'd0);
        cyc(1, 0, 0, 1, 24'h000123, 1);
        chk(s_stall === 1'b1, "R1", "first conflict misses", 64'(s_stall), 64'd1);
        // R4: fill cycle ignores a conflicting request on its inputs
        cyc(1, 0, 0, 1, 24'h0ABCD7, 1);
        chk(s_fetch === 1'b1 && s_word === memf(24'h000123), "R4", "fill delivers stalled word",
            64'(s_word), 64'(memf(24'h000123)));
        // R5: same address now hits; different tag same set misses
        cyc(1, 0, 0, 1, 24'h000123, 1);
        chk(s_hit === 1'b1, "R5", "refetch hits", 64'(s_hit), 64'd1);
        cyc(1, 0, 0, 1, 24'h0ABCD7, 1);
        chk(s_stall === 1'b1, "R4", "ignored fill-cycle request did not allocate", 64'(s_stall), 64'd1);
        cyc(1, 0, 0, 0, 24'h0, 0);

        // R2: bypass never allocates
        cyc(1, 0, 0, 1, 24'h00F00E, 0);
        chk(s_fetch === 1'b1 && !s_hit, "R2", "bypass fetch", 64'(s_fetch), 64'd1);
        cyc(1, 0, 0, 1, 24'h00F00E, 1);
        chk(s_stall === 1'b1, "R2", "bypass did not allocate", 64'(s_stall), 64'd1);
        cyc(1, 0, 0, 0, 24'h0, 0);

        // R6: way choice and replacement bit in set 5
        conflict(24'h000015, 0);
        conflict(24'h000025, 0);
        conflict(24'h000015, 0);
        chk(s_hit === 1'b1, "R6", "way0 entry hits", 64'(s_hit), 64'd1);
        conflict(24'h000035, 0);
        cyc(1, 0, 0, 1, 24'h000015, 1);
        chk(s_hit === 1'b1, "R6", "recently used way kept", 64'(s_hit), 64'd1);
        cyc(1, 0, 0, 1, 24'h000025, 1);
        chk(s_stall === 1'b1, "R6", "LRU way replaced", 64'(s_stall), 64'd1);
        cyc(1, 0, 0, 0, 24'h0, 0);

        // R7: freeze blocks fills but serves hits
        cyc(1, 1, 0, 1, 24'h000777, 1);
        cyc(1, 1, 0, 0, 24'h0, 0);
        cyc(1, 1, 0, 1, 24'h000777, 1);
        chk(s_stall === 1'b1, "R7", "frozen fill not kept", 64'(s_stall), 64'd1);
        cyc(1, 0, 0, 0, 24'h0, 0);
        cyc(1, 1, 0, 1, 24'h000015, 1);
        chk(s_hit === 1'b1, "R7", "hit while frozen", 64'(s_hit), 64'd1);

        // R9: disable stalls, keeps contents
        cyc(0, 0, 0, 1, 24'h000015, 1);
        chk(s_stall === 1'b1 && !s_hit, "R9", "disabled conflict stalls", 64'(s_stall), 64'd1);
        cyc(0, 0, 0, 0, 24'h0, 0);
        cyc(1, 0, 0, 1, 24'h000015, 1);
        chk(s_hit === 1'b1, "R9", "contents survive disable", 64'(s_hit), 64'd1);

        // R8: flush with a fill in the same cycle
        cyc(1, 0, 0, 1, 24'h000444, 1);
        cyc(1, 0, 1, 0, 24'h0, 0);
        cyc(1, 0, 0, 1, 24'h000015, 1);
        chk(s_stall === 1'b1, "R8", "flushed entry misses", 64'(s_stall), 64'd1);
        cyc(1, 0, 0, 0, 24'h0, 0);
        cyc(1, 0, 0, 1, 24'h000444, 1);
        chk(s_stall === 1'b1, "R8", "fill during flush discarded", 64'(s_stall), 64'd1);
        cyc(1, 0, 0, 0, 24'h0, 0);

        // random mix over a small address pool (R2..R9 via the model)
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] a;
            a = {18'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3))};
            cyc(($urandom_range(0, 9) != 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 49) == 0), ($urandom_range(0, 3) != 0), a,
                ($urandom_range(0, 1) == 1));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule